// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches an input port of `WIDTH` pins and raises interrupt status for each pin according to how software has set that pin up. A pin can be set to sense a rising edge, a falling edge, either edge, a high level or a low level. The pin inputs are asynchronous. Each one passes through a synchronizer of `SYNC_STAGES` flops before any comparison is made.

For each pin the block keeps a raw status bit and a masked status bit. It also drives one combined interrupt request, which is the OR of all masked bits. Raw status from an edge stays latched until software clears it. Raw status from a level tracks the synchronized pin.

Software sets the block up through a simple write port. Each write carries a register select and a data word with one bit per pin. The selects are: sense mode, any-edge, polarity, mask and clear. The interrupt controller that consumes the request and the pad logic that feeds the pins are outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: A change on `pin_in` is first visible in `raw_stat` after the third rising clock edge that follows the change. It is not visible after the second.
- R2: A pin with sense=0 (edge), any-edge=0 and polarity=1 sets its raw bit when its synchronized value goes from 0 to 1. It does not set its raw bit when the value goes from 1 to 0.
- R3: A pin with sense=0, any-edge=0 and polarity=0 sets its raw bit on a 1-to-0 transition. It does not set its raw bit on a 0-to-1 transition.
- R4: A pin with sense=0 and any-edge=1 sets its raw bit on both transitions, whatever its polarity bit holds.
- R5: A pin with sense=1 (level) has a raw bit equal to (synchronized pin == polarity), where polarity 1 means high and 0 means low. A clear write has no effect on that bit.
- R6: An edge-set raw bit stays at 1 until a clear write carries 1 in that bit position. Clear bits written as 0 leave their raw bits unchanged.
- R7: If an edge on a pin sets its raw bit in the same cycle that a clear of that bit is written, the raw bit stays 1.
- R8: `mask_stat` equals `raw_stat` AND mask, and `irq` is the OR of `mask_stat`. Both update in the same cycle as `raw_stat`.
- R9: After a synchronous reset, `raw_stat`, `mask_stat` and `irq` are 0. Every pin then senses falling edges, and every pin is masked.
- R10: A write with `wr_en`=1 applies `wr_data` to the register chosen by `wr_sel`: 0 sense, 1 any-edge, 2 polarity, 3 mask, 4 clear. The write takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | WIDTH | Asynchronous pin values |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | WIDTH | Write data, one bit per pin |
| raw_stat | output | WIDTH | Raw interrupt status |
| mask_stat | output | WIDTH | Raw status gated by the mask |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchronizer. With eight pins, a single test pass can drive all pins through every one of the five sense modes. The mask pattern 0xA5 exercises both masked and unmasked pins in every step. A short synchronizer keeps the three-edge latency small enough to probe one edge before it and one edge after it. The same-cycle clear-versus-edge case can also be aimed at an exact cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    SEL_SENSE = 3'd0,
    SEL_ANY   = 3'd1,
    SEL_POL   = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_CLEAR = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] sense_q,
  output logic [WIDTH-1:0] any_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] mask_d,
  output logic [WIDTH-1:0] clr
);
  logic hit_mask;

  assign hit_mask = wr_en && (wr_sel == SEL_MASK);
  assign mask_d   = hit_mask ? wr_data : mask_q;
  assign clr      = (wr_en && (wr_sel == SEL_CLEAR)) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      any_q   <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else begin
      mask_q <= mask_d;
      if (wr_en) begin
        case (wr_sel)
          SEL_SENSE: sense_q <= wr_data;
          SEL_ANY:   any_q   <= wr_data;
          SEL_POL:   pol_q   <= wr_data;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst,
  input  logic s,
  input  logic sense,
  input  logic any,
  input  logic pol,
  input  logic clr,
  output logic raw_d,
  output logic raw_q
);
  logic prev;
  logic rise;
  logic fall;
  logic edge_hit;

  assign rise     = s & ~prev;
  assign fall     = ~s & prev;
  assign edge_hit = any ? (rise | fall) : (pol ? rise : fall);

  always_comb begin
    if (sense) raw_d = (s == pol);
    else       raw_d = (raw_q & ~clr) | edge_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      raw_q <= 1'b0;
    end else begin
      prev  <= s;
      raw_q <= raw_d;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] raw_stat,
  output logic [WIDTH-1:0] mask_stat,
  output logic             irq
);
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] sense_q, any_q, pol_q, mask_q, mask_d, clr;
  logic [WIDTH-1:0] raw_d;
  logic [WIDTH-1:0] gated_d;

  gpio_irq_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  gpio_irq_cfg #(.WIDTH(WIDTH)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sense_q(sense_q), .any_q(any_q), .pol_q(pol_q),
    .mask_q(mask_q), .mask_d(mask_d), .clr(clr)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    gpio_irq_pin pin_i (
      .clk(clk), .rst(rst), .s(pin_s[g]),
      .sense(sense_q[g]), .any(any_q[g]), .pol(pol_q[g]), .clr(clr[g]),
      .raw_d(raw_d[g]), .raw_q(raw_stat[g])
    );
  end

  assign gated_d = raw_d & mask_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_stat <= '0;
      irq       <= 1'b0;
    end else begin
      mask_stat <= gated_d;
      irq       <= |gated_d;
    end
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] pin_s,
  input logic [WIDTH-1:0] sense_q,
  input logic [WIDTH-1:0] any_q,
  input logic [WIDTH-1:0] pol_q,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] clr,
  input logic [WIDTH-1:0] raw_stat,
  input logic [WIDTH-1:0] mask_stat,
  input logic             irq
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  // R8: masked status is raw status gated by the mask register
  a_r8_masked_and: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    mask_stat == (raw_stat & mask_q));

  // R8: combined request is the OR of masked status
  a_r8_irq_or: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    irq == (|mask_stat));

  // R6: an edge-mode raw bit that is set stays set unless cleared
  a_r6_edge_hold: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    1'b1 |=> ($past(rst) || ((($past(raw_stat) & ~$past(sense_q) & ~$past(clr)) & ~raw_stat) == '0)));

  // R5: a level-mode raw bit follows the synchronized pin compared to polarity
  a_r5_level_follow: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    1'b1 |=> ($past(rst) || (((raw_stat ^ ~($past(pin_s) ^ $past(pol_q))) & $past(sense_q)) == '0)));

  // R4: any-edge mode pin sets on every synchronized transition
  a_r4_any_edge: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    1'b1 |=> ($past(rst) || $past(rst, 2) ||
      ((($past(pin_s) ^ $past(pin_s, 2)) & $past(any_q) & ~$past(sense_q) & ~raw_stat) == '0)));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .pin_s(pin_s), .sense_q(sense_q), .any_q(any_q),
  .pol_q(pol_q), .mask_q(mask_q), .clr(clr), .raw_stat(raw_stat),
  .mask_stat(mask_stat), .irq(irq)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] MSK = 8'hA5;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] pin_in;
  logic wr_en;
  logic [2:0] wr_sel;
  logic [W-1:0] wr_data;
  logic [W-1:0] raw_stat, mask_stat;
  logic irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sel, logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic chk(string req, logic [W-1:0] exp_raw, logic [W-1:0] m);
    logic [W-1:0] em;
    em = exp_raw & m;
    n_chk += 3;
    if (raw_stat !== exp_raw) begin
      n_err++; $display("FAIL %s raw_stat actual %h expected %h", req, raw_stat, exp_raw);
    end
    if (mask_stat !== em) begin
      n_err++; $display("FAIL %s mask_stat actual %h expected %h", req, mask_stat, em);
    end
    if (irq !== (|em)) begin
      n_err++; $display("FAIL %s irq actual %b expected %b", req, irq, |em);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
  endtask

  initial begin
    logic [W-1:0] e0, e1, e2, e3, e4;
    logic [W-1:0] se, an, po;
    string nm;
    rst = 1'b1; pin_in = '1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    tick(2);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset", 8'h00, 8'h00);
    tick(4);
    chk("R9 default ignores rising", 8'h00, 8'h00);
    pin_in = '0; tick(3);
    chk("R9 default falling masked", 8'hFF, 8'h00);

    for (int m = 0; m < 5; m++) begin
      pin_in = '0;
      do_reset();
      case (m)
        0: begin nm = "R2"; se = 0;  an = 0;  po = '1; e1 = '1; e3 = 0;  end
        1: begin nm = "R3"; se = 0;  an = 0;  po = 0;  e1 = 0;  e3 = '1; end
        2: begin nm = "R4"; se = 0;  an = '1; po = '1; e1 = '1; e3 = '1; end
        3: begin nm = "R5"; se = '1; an = 0;  po = '1; e1 = '1; e3 = 0;  end
        default: begin nm = "R5"; se = '1; an = '1; po = 0; e1 = 0; e3 = '1; end
      endcase
      wr(3'd0, se); wr(3'd1, an); wr(3'd2, po); wr(3'd3, MSK);
      tick(2);
      e0 = (m == 4) ? 8'hFF : 8'h00;
      wr(3'd4, 8'hFF);
      chk({nm, " R10 setup"}, e0, MSK);
      pin_in = '1;
      tick(2);
      chk("R1 not before third edge", e0, MSK);
      tick(1);
      chk({nm, " R1 after rise"}, e1, MSK);
      wr(3'd4, 8'h0F);
      e2 = se[0] ? e1 : (e1 & 8'hF0);
      chk({nm, " R6 partial clear"}, e2, MSK);
      wr(3'd4, 8'hFF);
      e2 = se[0] ? e1 : 8'h00;
      chk({nm, " R6 full clear"}, e2, MSK);
      pin_in = '0;
      tick(3);
      chk({nm, " after fall"}, e3, MSK);
      tick(3);
      chk({nm, " R6 holds"}, e3, MSK);
      wr(3'd3, 8'h00);
      chk("R8 mask off", e3, 8'h00);
      wr(3'd3, 8'hFF);
      wr(3'd4, 8'hFF);
      e4 = se[0] ? e3 : 8'h00;
      chk({nm, " R5 R6 clear after fall"}, e4, 8'hFF);
    end

    pin_in = '0;
    do_reset();
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    tick(2);
    pin_in = 8'h3C;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'hFF;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk("R7 edge beats clear", 8'h3C, 8'hFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule